// File: doc/BRIEF.md
# IDE PIO Cycle Timer

This block times one programmed-I/O read or write cycle on an IDE/ATA bus, with every interval counted in bus clocks. It holds two timing bytes, one for data-port cycles and one for command/control-port cycles. Both drives on the channel share them. When a cycle is requested, the block selects one byte and runs an address setup interval, an active interval and a hold/recovery interval, in that order. It drives the read strobe or the write strobe low only during the active interval, and then raises a one-clock completion pulse.

Each timing byte has three fields. The two top bits give the setup length. The middle three bits give the hold length, and the low three bits give the active length. The hold and active codes are not linear: their top codes jump to 8, 12 and 16 clocks. When the ready-wait feature is enabled, a slow drive can keep the active interval open past its programmed length by holding its ready line low. The ready line passes through a synchronizer before the timer uses it.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, busy and done are low and both strobes are high. The data-port timing byte resets to 0xF5 (setup 4, hold 8, active 8 clocks) and the command-port byte resets to 0xDE (setup 4, hold 4, active 12 clocks).
- R2: Timing byte bits 7:6 give the setup length. Code n lasts n+1 clocks, so codes 0 to 3 give 1 to 4 clocks.
- R3: Timing byte bits 2:0 give the active length. Codes 0 to 7 give 2, 3, 4, 5, 6, 8, 12 and 16 clocks.
- R4: Timing byte bits 5:3 give the hold length. Codes 0 to 7 give 1, 2, 3, 4, 5, 6, 8 and 12 clocks.
- R5: A start request sampled while idle begins a cycle on the next clock. Busy is high through setup, active, hold and one completion clock in which done is high. The block is idle on the clock after that.
- R6: When isWrite=1, diowN is low exactly during the active interval and diorN stays high. When isWrite=0, the roles of the two strobes are swapped.
- R7: A write with cfgWe=1 stores cfgData into the command-port byte when cfgSelCmd=1 and into the data-port byte when cfgSelCmd=0. A cycle uses the command-port byte when useCmdTiming=1 and the data-port byte when useCmdTiming=0.
- R8: With iordyEnable=1, the active interval ends only after its programmed count has elapsed and the synchronized ready line is high. After iordy rises, the strobe stays low for exactly 2 more clocks. With iordyEnable=0, iordy has no effect.
- R9: A start request seen while a cycle is in progress, including the completion clock, is ignored and does not restart or lengthen the cycle.
- R10: The timing fields and the write flag are captured at the start of a cycle. A timing byte written during a cycle does not change that cycle and takes effect from the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Timing byte write strobe |
| cfgSelCmd | input | 1 | Write target: 1 = command-port byte, 0 = data-port byte |
| cfgData | input | 8 | Timing byte value to write |
| startReq | input | 1 | Cycle start request |
| isWrite | input | 1 | 1 = write cycle (diowN), 0 = read cycle (diorN) |
| useCmdTiming | input | 1 | 1 = use command-port byte, 0 = use data-port byte |
| iordyEnable | input | 1 | Enables stretching of the active interval by iordy |
| iordy | input | 1 | Drive ready line, asynchronous |
| diorN | output | 1 | Read strobe, active low |
| diowN | output | 1 | Write strobe, active low |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench measures each interval by counting clocks at the ports. It sweeps every setup, hold and active code, and it uses bytes whose hold and active codes differ. A decoder with swapped fields, a linear mapping for the top codes, or a counter that is off by one would therefore show up as a wrong count. The ready-wait case holds the strobe for a long time and then times the release. A missing or doubled synchronizer stage would change the 2-clock tail, and a timer that ignores the enable would stretch cycles it should not. Two more cases check for errors in the start logic and the capture logic. A start held high through a whole cycle would expose a restart. A timing byte rewritten during setup would expose fields that are read live instead of captured, because the running cycle would pick up the new values.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;

  localparam int TBYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_HOLD,
    PH_DONE
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic startCycle;   // capture timing, load setup count
    logic enterActive;  // load active count
    logic enterHold;    // load hold count
    logic countDown;    // decrement running count
  } tmr_ctl_t;

  // datapath -> control status
  typedef struct packed {
    logic cntZero;
    logic iordyOk;
  } tmr_stat_t;

  function automatic int unsigned setupClocks(input logic [1:0] code);
    return 32'(code) + 32'd1;
  endfunction

  function automatic int unsigned holdClocks(input logic [2:0] code);
    case (code)
      3'd6:    return 32'd8;
      3'd7:    return 32'd12;
      default: return 32'(code) + 32'd1;
    endcase
  endfunction

  function automatic int unsigned activeClocks(input logic [2:0] code);
    case (code)
      3'd5:    return 32'd8;
      3'd6:    return 32'd12;
      3'd7:    return 32'd16;
      default: return 32'(code) + 32'd2;
    endcase
  endfunction

endpackage

// File: rtl/pio_timer_datapath.sv
module pio_timer_datapath
  import pio_timer_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] DATA_RST = 8'hF5,
  parameter logic [7:0] CMD_RST = 8'hDE
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_ctl_t         ctl,
  input  logic             cfgWe,
  input  logic             cfgSelCmd,
  input  logic [TBYTE_W-1:0] cfgData,
  input  logic             useCmdTiming,
  input  logic             isWrite,
  input  logic             iordyEnable,
  input  logic             iordy,
  output tmr_stat_t        stat,
  output logic             snapWrite
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [TBYTE_W-1:0] dataTimingQ;
  logic [TBYTE_W-1:0] cmdTimingQ;
  logic [TBYTE_W-1:0] selByte;
  logic [2:0]         snapActive;
  logic [2:0]         snapHold;
  logic [CNT_W-1:0]   cnt;
  logic [SYNC_STAGES-1:0] syncQ;

  // timing byte storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataTimingQ <= DATA_RST;
      cmdTimingQ  <= CMD_RST;
    end else if (cfgWe) begin
      if (cfgSelCmd) cmdTimingQ <= cfgData;
      else           dataTimingQ <= cfgData;
    end
  end

  assign selByte = useCmdTiming ? cmdTimingQ : dataTimingQ;

  // per-cycle capture of fields and direction
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapActive <= '0;
      snapHold   <= '0;
      snapWrite  <= 1'b0;
    end else if (ctl.startCycle) begin
      snapActive <= selByte[2:0];
      snapHold   <= selByte[5:3];
      snapWrite  <= isWrite;
    end
  end

  // single shared interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= CNT_ZERO;
    end else if (ctl.startCycle) begin
      cnt <= CNT_W'(setupClocks(selByte[7:6]) - 32'd1);
    end else if (ctl.enterActive) begin
      cnt <= CNT_W'(activeClocks(snapActive) - 32'd1);
    end else if (ctl.enterHold) begin
      cnt <= CNT_W'(holdClocks(snapHold) - 32'd1);
    end else if (ctl.countDown && cnt != CNT_ZERO) begin
      cnt <= cnt - 1'b1;
    end
  end

  // ready synchronizer
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= iordy;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign stat.cntZero = (cnt == CNT_ZERO);
  assign stat.iordyOk = !iordyEnable || syncQ[SYNC_STAGES-1];

  // counter never moves while no cycle runs
  assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl == '0 && $past(ctl) == '0) |-> $stable(cnt));

endmodule

// File: rtl/pio_timer_ctrl.sv
module pio_timer_ctrl
  import pio_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  tmr_stat_t stat,
  input  logic      snapWrite,
  output tmr_ctl_t  ctl,
  output logic      diorN,
  output logic      diowN,
  output logic      busy,
  output logic      done
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    case (phase)
      PH_IDLE: begin
        if (startReq) begin
          ctl.startCycle = 1'b1;
          phaseNext      = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (stat.cntZero) begin
          ctl.enterActive = 1'b1;
          phaseNext       = PH_ACTIVE;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (stat.cntZero && stat.iordyOk) begin
          ctl.enterHold = 1'b1;
          phaseNext     = PH_HOLD;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      PH_HOLD: begin
        if (stat.cntZero) phaseNext = PH_DONE;
        else              ctl.countDown = 1'b1;
      end
      PH_DONE:  phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  assign diorN = !(phase == PH_ACTIVE && !snapWrite);
  assign diowN = !(phase == PH_ACTIVE &&  snapWrite);
  assign busy  = (phase != PH_IDLE);
  assign done  = (phase == PH_DONE);

  assert_done_after_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(phase) == PH_HOLD);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_active_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE) |-> ($past(phase) == PH_SETUP || $past(phase) == PH_ACTIVE));

  assert_iordy_stretch_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE && !stat.iordyOk) |=> phase == PH_ACTIVE);

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE || phase == PH_HOLD || phase == PH_DONE) |=> phase != PH_SETUP);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!diorN && !diowN));

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
  import pio_timer_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] DATA_RST = 8'hF5,
  parameter logic [7:0] CMD_RST = 8'hDE
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       cfgSelCmd,
  input  logic [7:0] cfgData,
  input  logic       startReq,
  input  logic       isWrite,
  input  logic       useCmdTiming,
  input  logic       iordyEnable,
  input  logic       iordy,
  output logic       diorN,
  output logic       diowN,
  output logic       busy,
  output logic       done
);

  tmr_ctl_t  ctl;
  tmr_stat_t stat;
  logic      snapWrite;

  pio_timer_datapath #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
    .DATA_RST(DATA_RST), .CMD_RST(CMD_RST)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cfgWe(cfgWe), .cfgSelCmd(cfgSelCmd), .cfgData(cfgData),
    .useCmdTiming(useCmdTiming), .isWrite(isWrite),
    .iordyEnable(iordyEnable), .iordy(iordy),
    .stat(stat), .snapWrite(snapWrite)
  );

  pio_timer_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .stat(stat), .snapWrite(snapWrite), .ctl(ctl),
    .diorN(diorN), .diowN(diowN), .busy(busy), .done(done)
  );

endmodule

// File: tb/tb_pio_cycle_timer.sv
module tb_pio_cycle_timer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0, cfgSelCmd = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic startReq = 1'b0, isWrite = 1'b0, useCmdTiming = 1'b0;
  logic iordyEnable = 1'b0, iordy = 1'b1;
  logic diorN, diowN, busy, done;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pio_cycle_timer dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSelCmd(cfgSelCmd),
    .cfgData(cfgData), .startReq(startReq), .isWrite(isWrite),
    .useCmdTiming(useCmdTiming), .iordyEnable(iordyEnable), .iordy(iordy),
    .diorN(diorN), .diowN(diowN), .busy(busy), .done(done)
  );

  typedef struct packed {
    logic [7:0] tbyte;
    logic       cmd;
    logic       wr;
    int         s;
    int         a;
    int         h;
  } vec_t;

  // every setup/hold/active code, plus two bytes with unequal hold and active codes
  localparam vec_t VECS [10] = '{
    '{8'h00, 1'b0, 1'b0, 1,  2,  1},
    '{8'h49, 1'b1, 1'b0, 2,  3,  2},
    '{8'h92, 1'b0, 1'b1, 3,  4,  3},
    '{8'hDB, 1'b1, 1'b1, 4,  5,  4},
    '{8'h24, 1'b0, 1'b0, 1,  6,  5},
    '{8'h6D, 1'b1, 1'b0, 2,  8,  6},
    '{8'hB6, 1'b0, 1'b1, 3, 12,  8},
    '{8'hFF, 1'b1, 1'b1, 4, 16, 12},
    '{8'h38, 1'b0, 1'b0, 1,  2, 12},
    '{8'hC7, 1'b1, 1'b1, 4, 16,  1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [7:0] val);
    @(negedge clk);
    cfgWe = 1'b1; cfgSelCmd = sel; cfgData = val;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // runs one cycle and counts clocks of each interval at the ports
  task automatic runCycle(input logic cmd, input logic wr, input bit holdStart,
                          input bit midWe, input logic midSel, input logic [7:0] midVal,
                          output int s, output int a, output int h, output int d,
                          output int wrong);
    bit seenDone = 0;
    bit wrote = 0;
    s = 0; a = 0; h = 0; d = 0; wrong = 0;
    @(negedge clk);
    useCmdTiming = cmd; isWrite = wr; startReq = 1'b1;
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      cfgWe = 1'b0;
      if (!holdStart) startReq = 1'b0;
      if ((wr ? !diorN : !diowN)) wrong++;
      if (done) begin
        d++; seenDone = 1; startReq = 1'b0;
      end else if (wr ? !diowN : !diorN) begin
        a++;
      end else if (busy && a == 0) begin
        s++;
        if (midWe && !wrote) begin
          cfgWe = 1'b1; cfgSelCmd = midSel; cfgData = midVal; wrote = 1;
        end
      end else if (busy) begin
        h++;
      end else if (seenDone || it > 2) begin
        break;
      end
    end
  endtask

  task automatic checkCycle(input string tag, input int s, input int a, input int h,
                            input int d, input int wrong, input int es, input int ea,
                            input int eh);
    chk(s == es, {tag, " R2 setup clocks"}, s, es);
    chk(a == ea, {tag, " R3 active clocks"}, a, ea);
    chk(h == eh, {tag, " R4 hold clocks"}, h, eh);
    chk(d == 1, {tag, " R5 done width"}, d, 1);
    chk(wrong == 0, {tag, " R6 wrong strobe clocks"}, wrong, 0);
    chk(busy == 1'b0, {tag, " R5 idle after done"}, int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int s, a, h, d, w, n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 busy/done in reset", int'({busy, done}), 0);
    chk(diorN == 1 && diowN == 1, "R1 strobes in reset", int'({diorN, diowN}), 3);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && diorN && diowN && !done, "R1 idle after reset",
        int'({busy, diorN, diowN, done}), 6);

    // R1, R7: default bytes (data 0xF5, command 0xDE)
    runCycle(1'b0, 1'b0, 0, 0, 1'b0, 8'h00, s, a, h, d, w);
    checkCycle("R1 R7 data default", s, a, h, d, w, 4, 8, 8);
    runCycle(1'b1, 1'b1, 0, 0, 1'b0, 8'h00, s, a, h, d, w);
    checkCycle("R1 R7 cmd default", s, a, h, d, w, 4, 12, 4);

    // R2 R3 R4 R6 R7: vector table
    foreach (VECS[i]) begin
      cfgWrite(VECS[i].cmd, VECS[i].tbyte);
      runCycle(VECS[i].cmd, VECS[i].wr, 0, 0, 1'b0, 8'h00, s, a, h, d, w);
      checkCycle($sformatf("vec%0d", i), s, a, h, d, w, VECS[i].s, VECS[i].a, VECS[i].h);
    end

    // R7: the other byte was left alone: cmd byte 0xC7, data byte 0x38
    runCycle(1'b0, 1'b1, 0, 0, 1'b0, 8'h00, s, a, h, d, w);
    checkCycle("R7 data byte kept", s, a, h, d, w, 1, 2, 12);

    // R9: start held high through the whole cycle
    cfgWrite(1'b0, 8'h09);
    runCycle(1'b0, 1'b0, 1, 0, 1'b0, 8'h00, s, a, h, d, w);
    checkCycle("R9 start held", s, a, h, d, w, 1, 3, 2);
    @(negedge clk);
    chk(busy == 1'b0, "R9 no restart", int'(busy), 0);

    // R10: write during setup does not affect running cycle
    cfgWrite(1'b0, 8'h00);
    runCycle(1'b0, 1'b1, 0, 1, 1'b0, 8'hFF, s, a, h, d, w);
    checkCycle("R10 current cycle", s, a, h, d, w, 1, 2, 1);
    runCycle(1'b0, 1'b1, 0, 0, 1'b0, 8'h00, s, a, h, d, w);
    checkCycle("R10 next cycle", s, a, h, d, w, 4, 16, 12);

    // R8: ready stretch with a 2-clock active byte
    cfgWrite(1'b0, 8'h00);
    iordyEnable = 1'b1; iordy = 1'b0;
    @(negedge clk);
    useCmdTiming = 1'b0; isWrite = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    n = 0;
    while (diorN && n < 50) begin n++; @(negedge clk); end
    repeat (20) @(negedge clk);
    chk(!diorN, "R8 strobe held while not ready", int'(diorN), 0);
    iordy = 1'b1;
    n = 0;
    @(negedge clk);
    while (!diorN && n < 100) begin n++; @(negedge clk); end
    chk(n == 2, "R8 release latency", n, 2);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end

    // R8: ready ignored when disabled
    iordyEnable = 1'b0; iordy = 1'b0;
    runCycle(1'b0, 1'b0, 0, 0, 1'b0, 8'h00, s, a, h, d, w);
    checkCycle("R8 ready disabled", s, a, h, d, w, 1, 2, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule